// File: doc/BRIEF.md
# System Control Register File

This block is the configuration register bank that sits next to a processor core and serves its coprocessor move instructions. On each cycle the core raises either a write strobe or a read strobe together with the 32-bit instruction word. A write strobe also carries a data word. The block picks the target register from two fields of the instruction word. A move-to updates the selected register. A move-from returns its value one clock later. An encoding that the block does not support raises an illegal-access pulse instead.

The bank stores the following registers:
- the system control word
- the coprocessor access word
- the translation table base
- the domain access word
- separate data-side and instruction-side fault status registers
- separate data-side and instruction-side fault address registers
- separate data-side and instruction-side lockdown registers
- the process-ID address offset
- the context ID

Identification reads come from a parameter and from fixed constants. Some encodings read as zero and discard writes. Writes that change translation state raise a one-cycle TLB-flush pulse for the address translation logic.

Top module: `sysctl_regfile`

## Requirements
- R1: The primary register number is insn[19:16] and the selector is insn[7:5]; all other instruction bits are ignored. Read data and the illegal pulse appear on the clock edge after the strobe. `illegal` and `tlb_flush` are single-cycle pulses that follow only a strobe, and `tlb_flush` follows only a write.
- R2: After reset every stored register reads 0, and `rdata`, `illegal` and `tlb_flush` are 0.
- R3: Register 0 is the identification register. Selector 1 reads 32'h01DD20D2, selector 2 reads 0, and every other selector reads the `CPU_ID` parameter. Any write to register 0 is illegal.
- R4: Register 1 selector 0 is the control word. It reads and writes normally, and a legal write pulses `tlb_flush`. Register 1 selector 2 is the coprocessor access word. It reads and writes normally and does not flush.
- R5: A read of register 1 selector 1 returns 1 when `AUX_CTRL_EN` is 1 and is illegal when it is 0. A write to register 1 selector 1 is always illegal, and register 1 selectors 3 to 7 are illegal for reads and writes.
- R6: Registers 2 (translation base) and 3 (domain access) read and write normally under any selector.
- R7: Registers 5 (fault status), 6 (fault address) and 9 (lockdown) each hold two words: the data-side word at selector 0 and the instruction-side word at selector 1. Any other selector is illegal.
- R8: A write to register 8 with selector 0 or 1 pulses `tlb_flush` and stores nothing. Register 8 with any other selector is an illegal write, and every read of register 8 is illegal.
- R9: Registers 4, 11, 12 and 14 are reserved, and both reads and writes to them are illegal.
- R10: Registers 7, 10 and 15 read as 0. Writes to them are accepted without an illegal pulse and change nothing.
- R11: Register 13 selector 0 is the process-ID offset and selector 1 is the context ID, both read/write. Other selectors are illegal.
- R12: An illegal access changes no register. An illegal read sets `rdata` to 0. Between reads `rdata` holds its last value. When both strobes are high, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Move-to strobe |
| rd_en | input | 1 | Move-from strobe |
| insn | input | 32 | Instruction word carrying register number and selector |
| wdata | input | 32 | Data for a move-to |
| rdata | output | 32 | Registered read data |
| illegal | output | 1 | Unsupported-encoding pulse, one cycle after the strobe |
| tlb_flush | output | 1 | TLB invalidate pulse, one cycle after a qualifying write |

## Verification
The assertions check several properties on every cycle:
- the pulse outputs appear only after a strobe, and a flush appears only after a write
- `rdata` holds steady when no read is made
- writes to the identification register and to reserved numbers are flagged
- reads of the TLB control register are flagged
- a control-word write flushes
- the cache-type constant is returned

Other behaviour can only be shown by the bench scenarios, which compare against a model of the register contents:
- register contents survive across accesses
- the data-side and instruction-side copies stay independent
- illegal and ignored writes leave state untouched
- a simultaneous read and write behaves as specified
- the auxiliary-control read changes with the parameter

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned SC_DW   = 32;
    localparam int unsigned PRI_LSB = 16;
    localparam int unsigned PRI_W   = 4;
    localparam int unsigned SEL_LSB = 5;
    localparam int unsigned SEL_W   = 3;

    localparam logic [SC_DW-1:0] CACHE_TYPE_VAL = 32'h01DD20D2;

    typedef enum logic [4:0] {
        T_NONE, T_CTRL, T_COPROC, T_TTB, T_DAC,
        T_FSR_D, T_FSR_I, T_FAR_D, T_FAR_I,
        T_LCK_D, T_LCK_I, T_PID, T_CTX,
        T_ID_MAIN, T_ID_CACHE, T_ZERO, T_AUX
    } tgt_e;

    typedef struct packed {
        logic [SC_DW-1:0] ctrl;
        logic [SC_DW-1:0] coproc;
        logic [SC_DW-1:0] ttb;
        logic [SC_DW-1:0] dac;
        logic [SC_DW-1:0] fsr_d;
        logic [SC_DW-1:0] fsr_i;
        logic [SC_DW-1:0] far_d;
        logic [SC_DW-1:0] far_i;
        logic [SC_DW-1:0] lck_d;
        logic [SC_DW-1:0] lck_i;
        logic [SC_DW-1:0] pid;
        logic [SC_DW-1:0] ctx;
    } regs_t;

    typedef struct packed {
        regs_t            r;
        logic [SC_DW-1:0] rdata;
        logic             illegal;
        logic             flush;
    } state_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter bit AUX_CTRL_EN = 1'b1
) (
    input  logic [PRI_W-1:0] pri,
    input  logic [SEL_W-1:0] sel,
    output tgt_e             tgt,
    output logic             rd_bad,
    output logic             wr_bad,
    output logic             wr_store,
    output logic             wr_flush
);

    always_comb begin
        tgt      = T_NONE;
        rd_bad   = 1'b0;
        wr_bad   = 1'b0;
        wr_store = 1'b0;
        wr_flush = 1'b0;
        unique case (pri)
            4'd0: begin
                wr_bad = 1'b1;
                if (sel == 3'd1)      tgt = T_ID_CACHE;
                else if (sel == 3'd2) tgt = T_ZERO;
                else                  tgt = T_ID_MAIN;
            end
            4'd1: begin
                unique case (sel)
                    3'd0: begin tgt = T_CTRL; wr_store = 1'b1; wr_flush = 1'b1; end
                    3'd1: begin tgt = T_AUX; wr_bad = 1'b1; rd_bad = !AUX_CTRL_EN; end
                    3'd2: begin tgt = T_COPROC; wr_store = 1'b1; end
                    default: begin rd_bad = 1'b1; wr_bad = 1'b1; end
                endcase
            end
            4'd2: begin tgt = T_TTB; wr_store = 1'b1; end
            4'd3: begin tgt = T_DAC; wr_store = 1'b1; end
            4'd5, 4'd6, 4'd9, 4'd13: begin
                if (sel > 3'd1) begin
                    rd_bad = 1'b1;
                    wr_bad = 1'b1;
                end else begin
                    wr_store = 1'b1;
                    case (pri)
                        4'd5:    tgt = sel[0] ? T_FSR_I : T_FSR_D;
                        4'd6:    tgt = sel[0] ? T_FAR_I : T_FAR_D;
                        4'd9:    tgt = sel[0] ? T_LCK_I : T_LCK_D;
                        default: tgt = sel[0] ? T_CTX   : T_PID;
                    endcase
                end
            end
            4'd7, 4'd10, 4'd15: tgt = T_ZERO;
            4'd8: begin
                rd_bad = 1'b1;
                if (sel > 3'd1) wr_bad = 1'b1;
                else            wr_flush = 1'b1;
            end
            default: begin
                rd_bad = 1'b1;
                wr_bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
#(
    parameter logic [SC_DW-1:0] CPU_ID = 32'h4106_9265
) (
    input  tgt_e             tgt,
    input  regs_t            regs,
    output logic [SC_DW-1:0] data
);

    always_comb begin
        unique case (tgt)
            T_CTRL:     data = regs.ctrl;
            T_COPROC:   data = regs.coproc;
            T_TTB:      data = regs.ttb;
            T_DAC:      data = regs.dac;
            T_FSR_D:    data = regs.fsr_d;
            T_FSR_I:    data = regs.fsr_i;
            T_FAR_D:    data = regs.far_d;
            T_FAR_I:    data = regs.far_i;
            T_LCK_D:    data = regs.lck_d;
            T_LCK_I:    data = regs.lck_i;
            T_PID:      data = regs.pid;
            T_CTX:      data = regs.ctx;
            T_ID_MAIN:  data = CPU_ID;
            T_ID_CACHE: data = CACHE_TYPE_VAL;
            T_AUX:      data = {{(SC_DW-1){1'b0}}, 1'b1};
            default:    data = '0;
        endcase
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter logic [SC_DW-1:0] CPU_ID      = 32'h4106_9265,
    parameter bit               AUX_CTRL_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [31:0]      insn,
    input  logic [SC_DW-1:0] wdata,
    output logic [SC_DW-1:0] rdata,
    output logic             illegal,
    output logic             tlb_flush
);

    logic [PRI_W-1:0] pri;
    logic [SEL_W-1:0] sel;
    logic             unused_insn_bits;

    assign pri = insn[PRI_LSB +: PRI_W];
    assign sel = insn[SEL_LSB +: SEL_W];
    assign unused_insn_bits = ^{insn[31:PRI_LSB+PRI_W], insn[PRI_LSB-1:SEL_LSB+SEL_W],
                                insn[SEL_LSB-1:0]};

    tgt_e             tgt;
    logic             rd_bad, wr_bad, wr_store, wr_flush;
    logic [SC_DW-1:0] rd_val;
    state_t           st_d, st_q;

    sysctl_decode #(.AUX_CTRL_EN(AUX_CTRL_EN)) u_decode (
        .pri      (pri),
        .sel      (sel),
        .tgt      (tgt),
        .rd_bad   (rd_bad),
        .wr_bad   (wr_bad),
        .wr_store (wr_store),
        .wr_flush (wr_flush)
    );

    sysctl_rdmux #(.CPU_ID(CPU_ID)) u_rdmux (
        .tgt  (tgt),
        .regs (st_q.r),
        .data (rd_val)
    );

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        st_d.flush   = 1'b0;
        if (wr_en) begin
            if (wr_bad) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.flush = wr_flush;
                if (wr_store) begin
                    case (tgt)
                        T_CTRL:   st_d.r.ctrl   = wdata;
                        T_COPROC: st_d.r.coproc = wdata;
                        T_TTB:    st_d.r.ttb    = wdata;
                        T_DAC:    st_d.r.dac    = wdata;
                        T_FSR_D:  st_d.r.fsr_d  = wdata;
                        T_FSR_I:  st_d.r.fsr_i  = wdata;
                        T_FAR_D:  st_d.r.far_d  = wdata;
                        T_FAR_I:  st_d.r.far_i  = wdata;
                        T_LCK_D:  st_d.r.lck_d  = wdata;
                        T_LCK_I:  st_d.r.lck_i  = wdata;
                        T_PID:    st_d.r.pid    = wdata;
                        T_CTX:    st_d.r.ctx    = wdata;
                        default:  ;
                    endcase
                end
            end
        end else if (rd_en) begin
            if (rd_bad) begin
                st_d.illegal = 1'b1;
                st_d.rdata   = '0;
            end else begin
                st_d.rdata = rd_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata     = st_q.rdata;
    assign illegal   = st_q.illegal;
    assign tlb_flush = st_q.flush;

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] insn,
    input logic [31:0] rdata,
    input logic        illegal,
    input logic        tlb_flush
);

    logic [3:0] pri;
    logic [2:0] sel;
    logic       rd_only;
    assign pri     = insn[19:16];
    assign sel     = insn[7:5];
    assign rd_only = rd_en && !wr_en;

    // R1: pulses only after a strobe
    a_r1_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal || tlb_flush) |-> $past(wr_en || rd_en));

    // R1: flush only after a write
    a_r1_flush_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !tlb_flush);

    // R3: identification register is read-only
    a_r3_id_write_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pri == 4'd0) |=> illegal);

    // R3: cache type constant
    a_r3_cache_type: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && pri == 4'd0 && sel == 3'd1) |=> (rdata == 32'h01DD20D2 && !illegal));

    // R4: control write flushes
    a_r4_ctrl_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pri == 4'd1 && sel == 3'd0) |=> (tlb_flush && !illegal));

    // R8: TLB control read illegal
    a_r8_read_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && pri == 4'd8) |=> (illegal && !tlb_flush));

    // R9: reserved numbers
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && (pri == 4'd4 || pri == 4'd11 || pri == 4'd12 || pri == 4'd14))
        |=> illegal);

    // R12: rdata holds without a read
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_only |=> $stable(rdata));

endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .insn      (insn),
    .rdata     (rdata),
    .illegal   (illegal),
    .tlb_flush (tlb_flush)
);

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb;

    localparam logic [31:0] CPU_ID = 32'h4106_9265;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_na;
    logic        illegal, tlb_flush, illegal_na, tlb_flush_na;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] m [12];
    logic [31:0] exp_rdata = '0;

    always #5 clk = ~clk;

    sysctl_regfile #(.CPU_ID(CPU_ID), .AUX_CTRL_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .insn(insn),
        .wdata(wdata), .rdata(rdata), .illegal(illegal), .tlb_flush(tlb_flush));

    sysctl_regfile #(.CPU_ID(CPU_ID), .AUX_CTRL_EN(1'b0)) u_noaux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .insn(insn),
        .wdata(wdata), .rdata(rdata_na), .illegal(illegal_na), .tlb_flush(tlb_flush_na));

    function automatic int slot(input logic [3:0] p, input logic [2:0] s);
        if (p == 4'd2) return 2;
        if (p == 4'd3) return 3;
        if (p == 4'd1 && s == 3'd0) return 0;
        if (p == 4'd1 && s == 3'd2) return 1;
        if (s > 3'd1) return -1;
        case (p)
            4'd5:    return 4 + s;
            4'd6:    return 6 + s;
            4'd9:    return 8 + s;
            4'd13:   return 10 + s;
            default: return -1;
        endcase
    endfunction

    function automatic string rtag(input logic [3:0] p, input logic [2:0] s);
        case (p)
            4'd0: return "R3";
            4'd1: return (s == 3'd0 || s == 3'd2) ? "R4" : "R5";
            4'd2, 4'd3: return "R6";
            4'd5, 4'd6, 4'd9: return "R7";
            4'd8: return "R8";
            4'd7, 4'd10, 4'd15: return "R10";
            4'd13: return "R11";
            default: return "R9";
        endcase
    endfunction

    task automatic access(input bit wr, input bit rd, input logic [3:0] p,
                          input logic [2:0] s, input logic [31:0] d, input string tag);
        bit e_bad, e_fl;
        int k;
        logic [31:0] w;
        e_bad = 1'b0; e_fl = 1'b0;
        k = slot(p, s);
        w = $urandom;
        w[19:16] = p;
        w[7:5]   = s;
        insn = w; wdata = d; wr_en = wr; rd_en = rd;
        if (wr) begin
            if (k >= 0) begin
                m[k] = d;
                e_fl = (k == 0);
            end else if (p == 4'd8 && s <= 3'd1) e_fl = 1'b1;
            else if (!(p == 4'd7 || p == 4'd10 || p == 4'd15)) e_bad = 1'b1;
        end else if (rd) begin
            if (k >= 0) exp_rdata = m[k];
            else if (p == 4'd0) exp_rdata = (s == 3'd1) ? 32'h01DD20D2 : (s == 3'd2) ? 32'h0 : CPU_ID;
            else if (p == 4'd1 && s == 3'd1) exp_rdata = 32'h1;
            else if (p == 4'd7 || p == 4'd10 || p == 4'd15) exp_rdata = 32'h0;
            else begin e_bad = 1'b1; exp_rdata = 32'h0; end
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        n_tests++;
        if (rdata !== exp_rdata || illegal !== e_bad || tlb_flush !== e_fl) begin
            n_fail++;
            $display("FAIL %s p=%0d s=%0d: rdata=%h/%h illegal=%b/%b flush=%b/%b (actual/expected)",
                     tag, p, s, rdata, exp_rdata, illegal, e_bad, tlb_flush, e_fl);
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] ex);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, ex);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        foreach (m[i]) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset values on outputs
        check(rdata === 0 && illegal === 0 && tlb_flush === 0, "R2 outputs", {rdata[31:2], illegal, tlb_flush}, 0);
        // R2: stored registers zero after reset
        access(0, 1, 4'd1, 3'd0, 0, "R2");
        access(0, 1, 4'd13, 3'd1, 0, "R2");
        access(0, 1, 4'd9, 3'd1, 0, "R2");
        // R3
        access(0, 1, 4'd0, 3'd0, 0, "R3");
        access(0, 1, 4'd0, 3'd1, 0, "R3");
        access(0, 1, 4'd0, 3'd2, 0, "R3");
        access(0, 1, 4'd0, 3'd6, 0, "R3");
        access(1, 0, 4'd0, 3'd0, 32'hDEAD_BEEF, "R3");
        // R4
        access(1, 0, 4'd1, 3'd0, 32'h0000_3005, "R4");
        access(0, 1, 4'd1, 3'd0, 0, "R4");
        access(1, 0, 4'd1, 3'd2, 32'h00F0_0000, "R4");
        access(0, 1, 4'd1, 3'd2, 0, "R4");
        // R5 with auxiliary control enabled, then disabled instance
        access(0, 1, 4'd1, 3'd1, 0, "R5");
        check(illegal_na === 1'b1 && rdata_na === 32'h0, "R5 noaux read", {31'h0, illegal_na}, 1);
        access(1, 0, 4'd1, 3'd1, 32'h1, "R5");
        access(0, 1, 4'd1, 3'd5, 0, "R5");
        // R7 independent copies
        access(1, 0, 4'd5, 3'd0, 32'h1111_0000, "R7");
        access(1, 0, 4'd5, 3'd1, 32'h2222_0000, "R7");
        access(0, 1, 4'd5, 3'd0, 0, "R7");
        // R8
        access(1, 0, 4'd8, 3'd1, 32'h5, "R8");
        access(1, 0, 4'd8, 3'd4, 32'h5, "R8");
        access(0, 1, 4'd8, 3'd0, 0, "R8");
        // R10 ignored write, then read back zero
        access(1, 0, 4'd10, 3'd0, 32'hFFFF_FFFF, "R10");
        access(0, 1, 4'd10, 3'd0, 0, "R10");
        // R12 illegal write leaves state; simultaneous strobes
        access(1, 0, 4'd6, 3'd3, 32'hABCD_0123, "R12");
        access(0, 1, 4'd6, 3'd0, 0, "R12");
        access(1, 1, 4'd13, 3'd0, 32'h0200_0000, "R12");
        access(0, 1, 4'd13, 3'd0, 0, "R11");
        // R9 reserved
        access(0, 1, 4'd12, 3'd0, 0, "R9");
        // R1: random mix, other instruction bits randomized
        for (int i = 0; i < 600; i++) begin
            logic [3:0] p;
            logic [2:0] s;
            int op;
            p  = 4'($urandom);
            s  = 3'($urandom_range(0, 3));
            op = $urandom_range(0, 2);
            access(op != 1, op != 0, p, s, $urandom, (op == 2) ? "R12" : rtag(p, s));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule